// File: doc/BRIEF.md
# Occupancy-Ranked Thread Fetch Selector

This block chooses, every cycle, which hardware thread contexts of a four-context simultaneous multithreading front end may fetch, and how many instruction slots each one gets. Each context reports how many of its instructions are waiting in the stages ahead of issue. It also reports whether it is active, whether it can fetch (ready), and whether an outside controller has held it back (blocked). The selector favours the context holding the fewest pre-issue instructions. A stalled context that is piling up work therefore loses fetch priority, and contexts that are making progress keep the shared window.

A two-bit mode input selects the policy. In one policy two contexts share a total width of eight slots, with the leader filled first. In another the width is split evenly. In a third one context takes all eight slots. The fourth ignores occupancy and rotates among eligible contexts. An optional occupancy cap stops a context from starting a new fetch block when it already holds too many pre-issue instructions. The limit depends on how many contexts are active.

The selection is a valid/ready stream toward the fetch unit. The outputs are combinational from the present inputs and are not held by back-pressure. The only state is the rotation pointer, and it moves only when a rotating selection is accepted (`sel_valid_o` and `sel_ready_i` both high in one cycle). While `sel_ready_i` is low the pointer holds, so the same context is offered again.

Top module: `fetch_select`

## Requirements
- R1: A context is eligible only when its `active_i`, `ready_i` and not-`blocked_i` conditions all hold. No slot ever names an ineligible context.
- R2: With `cap_en_i` high, an otherwise eligible context is excluded in two cases. With exactly two active contexts it is excluded when its count exceeds 20. With three or more active contexts it is excluded when its count exceeds 15. With one or no active context, or with `cap_en_i` low, no cap applies.
- R3: Slot 0 names the eligible context with the smallest count. Slot 1 names the eligible context with the next smallest count. Equal counts go to the lower thread ID.
- R4: Mode 0 (dual, fill first): `sel0_budget_o` = min(avail of slot 0, 8). The slot 1 budget is min(avail of slot 1, 8 minus the slot 0 budget). `sel1_valid_o` is high only if a second eligible context exists and its budget is non-zero.
- R5: Mode 1 (dual, even split): each selected slot gets a budget of exactly 4, whatever the avail values. `sel1_valid_o` is high whenever a second eligible context exists.
- R6: Mode 2 (single): only slot 0 is used, with a budget of 8. `sel1_valid_o` stays low.
- R7: Mode 3 (rotate): slot 0 is the first eligible context at or after the rotation pointer, in ascending ID order with wrap-around, and counts are ignored. Its budget is 8 and slot 1 stays low. After reset the pointer is 0. When a selection in this mode is accepted, the pointer moves to the chosen ID plus one, modulo 4.
- R8: With no eligible context, `sel_valid_o` and `sel1_valid_o` are low, and both TIDs and both budgets are 0.
- R9: While `sel_ready_i` is low, or while the mode is not 3, the rotation pointer does not move. A later rotating selection then names the same context it would have named before the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Policy: 0 dual fill, 1 dual even, 2 single, 3 rotate |
| cap_en_i | input | 1 | Enables the occupancy cap |
| active_i | input | 4 | Context is running |
| ready_i | input | 4 | Context can fetch this cycle |
| blocked_i | input | 4 | Context held back by an outside controller |
| icount_i | input | 28 | Pre-issue instruction counts, 7 bits per context, context t at bits [7t+6:7t] |
| avail_i | input | 16 | Instructions each context could fetch, 4 bits per context, context t at bits [4t+3:4t] |
| sel_ready_i | input | 1 | Fetch unit accepts the selection |
| sel_valid_o | output | 1 | Slot 0 holds a selection |
| sel0_tid_o | output | 2 | Slot 0 thread ID |
| sel0_budget_o | output | 4 | Slot 0 instruction budget |
| sel1_valid_o | output | 1 | Slot 1 holds a selection |
| sel1_tid_o | output | 2 | Slot 1 thread ID |
| sel1_budget_o | output | 4 | Slot 1 instruction budget |

## Verification
The bench builds the block with its defaults: four contexts, 7-bit counts, a width of eight, and cap limits of 20 and 15. Counts are drawn mostly from 0 to 31, so both cap limits are crossed often and equal counts happen regularly, which tests the tie rule. Directed cases probe counts of exactly 20/21 and 15/16, a single active context far above either limit, and fill-first budgets that leave nothing for slot 1. Back-pressure is tested by holding ready low in rotate mode and then checking that the pointer resumes from where it stopped.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  typedef enum logic [1:0] {
    FM_DUAL_FILL = 2'd0,
    FM_DUAL_HALF = 2'd1,
    FM_SINGLE    = 2'd2,
    FM_ROTATE    = 2'd3
  } fmode_e;
endpackage

// File: rtl/fsel_elig.sv
module fsel_elig #(
  parameter int N        = 4,
  parameter int CW       = 7,
  parameter int CAP_PAIR = 20,
  parameter int CAP_MANY = 15
) (
  input  logic [N-1:0]    active,
  input  logic [N-1:0]    ready,
  input  logic [N-1:0]    blocked,
  input  logic            cap_en,
  input  logic [N*CW-1:0] counts,
  output logic [N-1:0]    elig
);
  localparam int AW = $clog2(N + 1);
  logic [AW-1:0] nact;
  logic [CW-1:0] limit;
  logic          capped;

  always_comb begin
    nact = '0;
    for (int t = 0; t < N; t++) nact = nact + AW'(active[t]);
    limit  = (nact == AW'(2)) ? CW'(CAP_PAIR) : CW'(CAP_MANY);
    capped = cap_en && (nact >= AW'(2));
  end

  for (genvar t = 0; t < N; t++) begin : g_elig
    assign elig[t] = active[t] && ready[t] && !blocked[t] &&
                     !(capped && (counts[t*CW +: CW] > limit));
  end
endmodule

// File: rtl/fsel_rank.sv
module fsel_rank #(
  parameter int N  = 4,
  parameter int CW = 7,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]    elig,
  input  logic [N*CW-1:0] counts,
  output logic            first_vld,
  output logic [IW-1:0]   first_id,
  output logic            second_vld,
  output logic [IW-1:0]   second_id
);
  logic [CW-1:0] cnt [N];
  logic [CW-1:0] best0, best1;

  for (genvar t = 0; t < N; t++) begin : g_unpack
    assign cnt[t] = counts[t*CW +: CW];
  end

  always_comb begin
    first_vld = 1'b0; first_id = '0; best0 = '0;
    for (int t = 0; t < N; t++) begin
      if (elig[t] && (!first_vld || cnt[t] < best0)) begin
        first_vld = 1'b1; first_id = IW'(t); best0 = cnt[t];
      end
    end
    second_vld = 1'b0; second_id = '0; best1 = '0;
    for (int t = 0; t < N; t++) begin
      if (elig[t] && (IW'(t) != first_id) && (!second_vld || cnt[t] < best1)) begin
        second_vld = 1'b1; second_id = IW'(t); best1 = cnt[t];
      end
    end
  end
endmodule

// File: rtl/fsel_rr.sv
module fsel_rr #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  elig,
  input  logic          advance,
  output logic          pick_vld,
  output logic [IW-1:0] pick_id
);
  logic [IW-1:0] ptr;
  int idx;

  always_comb begin
    pick_vld = 1'b0; pick_id = '0; idx = 0;
    for (int k = N - 1; k >= 0; k--) begin
      idx = int'(ptr) + k;
      if (idx >= N) idx = idx - N;
      if (elig[idx]) begin
        pick_vld = 1'b1; pick_id = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (advance && pick_vld)
      ptr <= (pick_id == IW'(N - 1)) ? '0 : pick_id + IW'(1);
  end

  assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(advance) |-> $stable(ptr));
endmodule

// File: rtl/fsel_budget.sv
module fsel_budget #(
  parameter int W = 8,
  localparam int BW = $clog2(W + 1)
) (
  input  fsel_pkg::fmode_e mode,
  input  logic             first_vld,
  input  logic             second_vld,
  input  logic [BW-1:0]    avail0,
  input  logic [BW-1:0]    avail1,
  output logic [BW-1:0]    b0,
  output logic [BW-1:0]    b1,
  output logic             v1
);
  import fsel_pkg::*;
  logic [BW-1:0] rest;

  always_comb begin
    b0 = '0; b1 = '0; v1 = 1'b0; rest = '0;
    if (first_vld) begin
      unique case (mode)
        FM_DUAL_FILL: begin
          b0   = (avail0 > BW'(W)) ? BW'(W) : avail0;
          rest = BW'(W) - b0;
          if (second_vld) begin
            b1 = (avail1 > rest) ? rest : avail1;
            v1 = (b1 != '0);
          end
        end
        FM_DUAL_HALF: begin
          b0 = BW'(W / 2);
          if (second_vld) begin
            b1 = BW'(W / 2); v1 = 1'b1;
          end
        end
        default: b0 = BW'(W);
      endcase
    end
  end
endmodule

// File: rtl/fetch_select.sv
module fetch_select #(
  parameter int N        = 4,
  parameter int CW       = 7,
  parameter int W        = 8,
  parameter int CAP_PAIR = 20,
  parameter int CAP_MANY = 15,
  localparam int IW = $clog2(N),
  localparam int BW = $clog2(W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_i,
  input  logic            cap_en_i,
  input  logic [N-1:0]    active_i,
  input  logic [N-1:0]    ready_i,
  input  logic [N-1:0]    blocked_i,
  input  logic [N*CW-1:0] icount_i,
  input  logic [N*BW-1:0] avail_i,
  input  logic            sel_ready_i,
  output logic            sel_valid_o,
  output logic [IW-1:0]   sel0_tid_o,
  output logic [BW-1:0]   sel0_budget_o,
  output logic            sel1_valid_o,
  output logic [IW-1:0]   sel1_tid_o,
  output logic [BW-1:0]   sel1_budget_o
);
  import fsel_pkg::*;
  fmode_e mode;
  logic [N-1:0] elig;
  logic f_vld, s_vld, r_vld, rotate;
  logic [IW-1:0] f_id, s_id, r_id, id0, id1;
  logic v0, v1r;
  logic [BW-1:0] b0, b1;

  assign mode   = fmode_e'(mode_i);
  assign rotate = (mode == FM_ROTATE);

  fsel_elig #(.N(N), .CW(CW), .CAP_PAIR(CAP_PAIR), .CAP_MANY(CAP_MANY)) u_elig (
    .active(active_i), .ready(ready_i), .blocked(blocked_i),
    .cap_en(cap_en_i), .counts(icount_i), .elig(elig));

  fsel_rank #(.N(N), .CW(CW)) u_rank (
    .elig(elig), .counts(icount_i), .first_vld(f_vld), .first_id(f_id),
    .second_vld(s_vld), .second_id(s_id));

  fsel_rr #(.N(N)) u_rr (
    .clk(clk), .rst_n(rst_n), .elig(elig),
    .advance(rotate && sel_ready_i), .pick_vld(r_vld), .pick_id(r_id));

  assign v0  = rotate ? r_vld : f_vld;
  assign id0 = rotate ? r_id : f_id;
  assign id1 = s_id;

  fsel_budget #(.W(W)) u_budget (
    .mode(mode), .first_vld(v0), .second_vld(s_vld && !rotate),
    .avail0(avail_i[id0*BW +: BW]), .avail1(avail_i[id1*BW +: BW]),
    .b0(b0), .b1(b1), .v1(v1r));

  assign sel_valid_o   = v0;
  assign sel0_tid_o    = v0 ? id0 : '0;
  assign sel0_budget_o = b0;
  assign sel1_valid_o  = v1r;
  assign sel1_tid_o    = v1r ? id1 : '0;
  assign sel1_budget_o = v1r ? b1 : '0;

  logic [CW-1:0] cnt_a [N];
  for (genvar t = 0; t < N; t++) begin : g_cnt
    assign cnt_a[t] = icount_i[t*CW +: CW];
  end

  assert_pick_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid_o |-> active_i[sel0_tid_o] && ready_i[sel0_tid_o] && !blocked_i[sel0_tid_o]);
  assert_cap_many_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid_o && cap_en_i && $countones(active_i) >= 3) |-> cnt_a[sel0_tid_o] <= CW'(CAP_MANY));
  assert_pair_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel1_valid_o |-> sel_valid_o && (sel1_tid_o != sel0_tid_o) && (cnt_a[sel0_tid_o] <= cnt_a[sel1_tid_o]));
  assert_width_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid_o |-> ({1'b0, sel0_budget_o} + {1'b0, sel1_budget_o}) <= (BW+1)'(W));
  assert_even_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd1 && sel1_valid_o) |-> (sel0_budget_o == BW'(W/2)) && (sel1_budget_o == BW'(W/2)));
  assert_single_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i[1] |-> !sel1_valid_o);
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid_o |-> !sel1_valid_o && sel0_budget_o == '0 && sel0_tid_o == '0);
endmodule

// File: tb/tb_fetch_select.sv
module tb_fetch_select;
  localparam int N = 4, CW = 7, W = 8, BW = 4;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode_i = 0;
  logic cap_en_i = 0, sel_ready_i = 1;
  logic [N-1:0] active_i = 0, ready_i = 0, blocked_i = 0;
  logic [N*CW-1:0] icount_i;
  logic [N*BW-1:0] avail_i;
  logic sel_valid_o, sel1_valid_o;
  logic [1:0] sel0_tid_o, sel1_tid_o;
  logic [BW-1:0] sel0_budget_o, sel1_budget_o;
  int cnt [N];
  int av [N];
  int mptr = 0, checks = 0, errors = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int t = 0; t < N; t++) begin
      icount_i[t*CW +: CW] = CW'(cnt[t]);
      avail_i[t*BW +: BW]  = BW'(av[t]);
    end
  end

  fetch_select dut (.*);

  task automatic expect_out(string tag);
    int nact, lim, f, s, r, e0, e1, eb0, eb1, idx;
    bit el [N];
    bit ev, ev1;
    nact = 0;
    for (int t = 0; t < N; t++) nact += active_i[t];
    lim = (nact == 2) ? 20 : 15;
    for (int t = 0; t < N; t++)
      el[t] = active_i[t] && ready_i[t] && !blocked_i[t] &&
              !(cap_en_i && nact >= 2 && cnt[t] > lim);
    f = -1; s = -1; r = -1;
    for (int t = 0; t < N; t++) if (el[t] && (f < 0 || cnt[t] < cnt[f])) f = t;
    for (int t = 0; t < N; t++) if (el[t] && t != f && (s < 0 || cnt[t] < cnt[s])) s = t;
    for (int k = 0; k < N; k++) begin
      idx = (mptr + k) % N;
      if (r < 0 && el[idx]) r = idx;
    end
    ev = 0; ev1 = 0; e0 = 0; e1 = 0; eb0 = 0; eb1 = 0;
    if (mode_i == 3) begin
      if (r >= 0) begin ev = 1; e0 = r; eb0 = 8; end
    end else if (f >= 0) begin
      ev = 1; e0 = f;
      if (mode_i == 2) eb0 = 8;
      else if (mode_i == 1) begin
        eb0 = 4;
        if (s >= 0) begin ev1 = 1; e1 = s; eb1 = 4; end
      end else begin
        eb0 = (av[f] > 8) ? 8 : av[f];
        if (s >= 0) begin
          eb1 = (av[s] > 8 - eb0) ? 8 - eb0 : av[s];
          if (eb1 != 0) begin ev1 = 1; e1 = s; end else eb1 = 0;
        end
      end
    end
    if (tag == "") begin
      if (!ev) tag = "R8";
      else case (mode_i) 0: tag = "R4"; 1: tag = "R5"; 2: tag = "R6"; default: tag = "R7"; endcase
    end
    checks++;
    if (sel_valid_o !== ev || sel0_tid_o !== 2'(e0) || sel0_budget_o !== BW'(eb0) ||
        sel1_valid_o !== ev1 || sel1_tid_o !== 2'(e1) || sel1_budget_o !== BW'(eb1)) begin
      errors++;
      $display("FAIL %s: got v=%0b t0=%0d b0=%0d v1=%0b t1=%0d b1=%0d exp v=%0b t0=%0d b0=%0d v1=%0b t1=%0d b1=%0d",
               tag, sel_valid_o, sel0_tid_o, sel0_budget_o, sel1_valid_o, sel1_tid_o, sel1_budget_o,
               ev, e0, eb0, ev1, e1, eb1);
    end
    if (mode_i == 3 && sel_ready_i && r >= 0) mptr = (r + 1) % N;
  endtask

  task automatic step(string tag);
    #2;
    expect_out(tag);
    @(negedge clk);
  endtask

  task automatic setc(int a, int b, int c, int d);
    cnt[0] = a; cnt[1] = b; cnt[2] = c; cnt[3] = d;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    setc(0, 0, 0, 0);
    for (int t = 0; t < N; t++) av[t] = 8;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state: nothing eligible (R8)
    step("R8");
    // R1: blocked / not ready / inactive excluded
    active_i = 4'hF; ready_i = 4'hF; blocked_i = 4'b0001; mode_i = 2; setc(1, 5, 3, 9);
    step("R1");
    ready_i = 4'b1011; step("R1");
    active_i = 4'b1010; step("R1");
    // R3 tie: equal counts go to lowest ID
    active_i = 4'hF; ready_i = 4'hF; blocked_i = 0; mode_i = 1; setc(7, 4, 4, 4);
    step("R3");
    // R2 cap with two active: 20 kept, 21 dropped
    cap_en_i = 1; active_i = 4'b0011; mode_i = 1; setc(20, 21, 0, 0);
    step("R2");
    // R2 cap with four active: 15 kept, 16 dropped
    active_i = 4'hF; setc(16, 15, 16, 40); step("R2");
    // R2 single active context: no cap
    active_i = 4'b0100; setc(0, 0, 100, 0); step("R2");
    cap_en_i = 0; active_i = 4'hF; setc(30, 40, 50, 60); step("R2");
    // R4: fill-first leaves nothing, then partial remainder
    mode_i = 0; setc(2, 3, 9, 9); av[0] = 8; av[1] = 5; step("R4");
    av[0] = 3; step("R4");
    av[0] = 12; step("R4");
    for (int t = 0; t < N; t++) av[t] = 8;
    // R8: all blocked
    blocked_i = 4'hF; step("R8");
    blocked_i = 0;
    // R7 rotation and R9 back-pressure hold
    mode_i = 3; setc(1, 2, 3, 4);
    step("R7"); step("R7");
    sel_ready_i = 0; step("R9"); step("R9");
    mode_i = 0; sel_ready_i = 1; step("R9");
    mode_i = 3; step("R9"); step("R7");
    // random
    for (int i = 0; i < 1500; i++) begin
      mode_i = 2'($urandom_range(0, 3));
      cap_en_i = 1'($urandom_range(0, 1));
      active_i = 4'($urandom_range(0, 15));
      ready_i = 4'($urandom_range(0, 15)) | 4'($urandom_range(0, 15));
      blocked_i = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
      sel_ready_i = ($urandom_range(0, 3) != 0);
      for (int t = 0; t < N; t++) begin
        cnt[t] = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 127) : $urandom_range(0, 31);
        av[t] = $urandom_range(0, 15);
      end
      step("");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule